// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is a serial slave that lets an external host read and write an on-chip register file over a three-wire link. The link has an active-low select, a serial clock and one shared data line. The data line is presented here as an input, an output and an output enable, and the pad ring joins them into a single bidirectional pin. Every transaction opens with a 16-bit command word. The command word holds the direction, a two-bit length code and a 13-bit starting register address. One or more 8-bit data bytes follow it, and each byte goes to the next register address in turn.

All link signals are brought into the system clock domain through two-flop synchronizers. Edges are detected in that domain, so the serial clock must run at no more than a quarter of the system clock. On the register-file side there is a single-cycle write strobe and a single-cycle read strobe, with a shared address bus. Read data is returned combinationally on `reg_rdata_i` in the same cycle as the read strobe.

Top module: `spi3_reg_slave`

## Requirements
- R1: The first 16 bits after select goes low form the command word, most significant bit first. Bit 15 selects the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address.
- R2: Length codes 2'b00, 2'b01 and 2'b10 allow 1, 2 and 3 data bytes. Any later bytes cause no write strobe and leave the data line undriven.
- R3: Length code 2'b11 allows an unlimited number of data bytes, until select rises.
- R4: The first data byte goes to the start address. Each later byte goes to the previous address plus one, wrapping modulo 2^13.
- R5: Write data is taken most significant bit first on rising serial clock edges. One write strobe fires for each complete byte. A partial byte cut off by select rising produces no strobe.
- R6: In a read, each byte is fetched with one read strobe. Its bits are driven most significant bit first, each one launched after a falling serial clock edge. The first bit follows the falling edge that comes after the last command bit.
- R7: The output enable is high only during the data phase of a read, for bytes the length code allows. It is low during the command word, during writes and whenever select is high.
- R8: After reset, and while select is high, no strobe fires and the output enable stays low.
- R9: Select rising in the middle of a command word abandons it. The next transaction parses a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven onto the line during reads |
| sdio_oe_o | output | 1 | Pad output enable for the data line |
| reg_addr_o | output | 13 | Register address for the current strobe |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_re_o | output | 1 | Single-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid while reg_re_o is high |

## Verification
The bench builds the block with its default 13-bit address, 8-bit data and two synchronizer stages, so the command word is exactly 16 bits. The serial clock runs at one twelfth of the system clock. It sweeps every direction and length code against host transfers of one to five bytes. This covers each fixed length being undershot, matched and overrun, and open-ended transfers of every size. Further cases start at the top of the address space to reach the wrap, cut off a byte partway through and abandon a command word. Expected write logs and read bytes are computed arithmetically from the address.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  localparam logic [1:0] LEN_OPEN = 2'b11;

  // done = bytes already finished in the data phase
  function automatic logic byte_allowed(input logic [1:0] len, input logic [1:0] done);
    return (len == LEN_OPEN) || (done <= len);
  endfunction
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi3_edge.sv
module spi3_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic csn_s_i,
  output logic cs_act_o,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;
  end

  assign cs_act_o = ~csn_s_i;
  assign rise_o   = cs_act_o &  sclk_s_i & ~sclk_q;
  assign fall_o   = cs_act_o & ~sclk_s_i &  sclk_q;
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              live_o
);
  localparam int CMD_W = ADDR_W + 3;
  localparam int CNT_W = $clog2(CMD_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  sh_q, sh_nxt;
  logic              rd_q;
  logic [1:0]        len_q;
  logic [1:0]        done_q, done_inc;
  logic [ADDR_W-1:0] addr_q, aout_q;
  logic [DATA_W-1:0] wd_q;
  logic              we_q, re_q;
  logic              allowed, allowed_next;

  assign sh_nxt       = {sh_q[CMD_W-2:0], bit_i};
  assign done_inc     = (done_q == 2'b11) ? 2'b11 : done_q + 2'd1;
  assign allowed      = byte_allowed(len_q, done_q);
  assign allowed_next = byte_allowed(len_q, done_inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      len_q   <= '0;
      done_q  <= '0;
      addr_q  <= '0;
      aout_q  <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        done_q  <= '0;
        rd_q    <= 1'b0;
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (phase_q == PH_CMD) begin
          if (cnt_q == CNT_W'(CMD_W-1)) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
            rd_q    <= sh_nxt[CMD_W-1];
            len_q   <= sh_nxt[CMD_W-2 -: 2];
            done_q  <= '0;
            if (sh_nxt[CMD_W-1]) begin
              // prefetch first read byte
              re_q   <= 1'b1;
              aout_q <= sh_nxt[ADDR_W-1:0];
              addr_q <= sh_nxt[ADDR_W-1:0] + 1'b1;
            end else begin
              addr_q <= sh_nxt[ADDR_W-1:0];
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == CNT_W'(DATA_W-1)) begin
            cnt_q  <= '0;
            done_q <= done_inc;
            if (!rd_q && allowed) begin
              we_q   <= 1'b1;
              aout_q <= addr_q;
              wd_q   <= sh_nxt[DATA_W-1:0];
              addr_q <= addr_q + 1'b1;
            end
            if (rd_q && allowed_next) begin
              re_q   <= 1'b1;
              aout_q <= addr_q;
              addr_q <= addr_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign we_o    = we_q;
  assign re_o    = re_q;
  assign addr_o  = aout_q;
  assign wdata_o = wd_q;
  assign live_o  = (phase_q == PH_DATA) && rd_q && allowed;
endmodule

// File: rtl/spi3_tx.sv
module spi3_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  input  logic              live_i,
  output logic              sdio_o,
  output logic              oe_o
);
  localparam int FCNT_W = $clog2(DATA_W);
  localparam logic [FCNT_W-1:0] BIT_TOP = FCNT_W'(DATA_W-1);

  logic [DATA_W-1:0] tx_q;
  logic [FCNT_W-1:0] fcnt_q;
  logic              sd_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      fcnt_q <= '0;
      sd_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (load_i) tx_q <= ldata_i;
      if (!cs_act_i || !live_i) begin
        oe_q <= 1'b0;
        if (!cs_act_i) fcnt_q <= '0;
      end else if (fall_i) begin
        sd_q   <= tx_q[BIT_TOP - fcnt_q];
        fcnt_q <= (fcnt_q == BIT_TOP) ? '0 : fcnt_q + 1'b1;
        oe_q   <= 1'b1;
      end
    end
  end

  assign sdio_o = sd_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic       cs_act, sclk_rise, sclk_fall;
  logic       rd_live, oe_int;

  spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdio_i, csn_i, sclk_i}),
    .q_o    (pins_s)
  );

  spi3_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (pins_s[0]),
    .csn_s_i  (pins_s[1]),
    .cs_act_o (cs_act),
    .rise_o   (sclk_rise),
    .fall_o   (sclk_fall)
  );

  spi3_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .rise_i   (sclk_rise),
    .bit_i    (pins_s[2]),
    .we_o     (reg_we_o),
    .re_o     (reg_re_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o),
    .live_o   (rd_live)
  );

  spi3_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .fall_i   (sclk_fall),
    .load_i   (reg_re_o),
    .ldata_i  (reg_rdata_i),
    .live_i   (rd_live),
    .sdio_o   (sdio_o),
    .oe_o     (oe_int)
  );

  // release the pad at once when select goes high, ahead of the synchronizer
  assign sdio_oe_o = oe_int & ~csn_i;
endmodule

// File: rtl/spi3_reg_slave_chk.sv
module spi3_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_i,
  input logic sdio_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic cs_act,
  input logic rd_live
);
  p_strobe_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  p_we_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_re_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  p_oe_cs_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> !csn_i);

  p_oe_read_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> $past(rd_live));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !(reg_we_o || reg_re_o));
endmodule

bind spi3_reg_slave spi3_reg_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .csn_i     (csn_i),
  .sdio_oe_o (sdio_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .cs_act    (cs_act),
  .rd_live   (rd_live)
);

// File: tb/sim_spi3_reg_slave.sv
module sim_spi3_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        csn = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo, oe;
  logic [12:0] raddr;
  logic [7:0]  wdata, rdata;
  logic        we, re;

  int n_chk = 0;
  int n_fail = 0;

  logic [12:0] log_a [32];
  logic [7:0]  log_d [32];
  int          wn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] wpat(input logic [12:0] a, input int k);
    return 8'(int'(a) * 3 + k * 37 + 5);
  endfunction

  function automatic int lim(input logic [1:0] len, input int nb);
    int cap;
    cap = (len == 2'b11) ? nb : int'(len) + 1;
    return (nb < cap) ? nb : cap;
  endfunction

  assign rdata = rf(raddr);

  spi3_reg_slave u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sclk_i      (sclk),
    .csn_i       (csn),
    .sdio_i      (sdi),
    .sdio_o      (sdo),
    .sdio_oe_o   (oe),
    .reg_addr_o  (raddr),
    .reg_wdata_o (wdata),
    .reg_we_o    (we),
    .reg_re_o    (re),
    .reg_rdata_i (rdata)
  );

  always @(posedge clk) begin
    if (rst_n && we) begin
      if (wn < 32) begin
        log_a[wn] <= raddr;
        log_d[wn] <= wdata;
      end
      wn <= wn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic got_oe, output logic got_bit);
    sdi = b;
    repeat (HALF) @(negedge clk);
    got_oe  = oe;
    got_bit = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // nbytes whole bytes, then extra_bits of a cut-off byte
  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] a,
                      input int nbytes, input int extra_bits);
    logic [15:0] cmd;
    logic        g_oe, g_b;
    logic [7:0]  rb, wb;
    int          oe_bad, wn0, exp_w, cap;
    wn0  = wn;
    cap  = lim(len, nbytes);
    cmd  = {rd, len, a};
    csn  = 1'b0;
    repeat (4) @(negedge clk);
    oe_bad = 0;
    for (int i = 15; i >= 0; i--) begin
      bit_cycle(cmd[i], g_oe, g_b);
      if (g_oe) oe_bad++;
    end
    chk(oe_bad == 0, "R7", "oe during command", oe_bad, 0);
    for (int k = 0; k < nbytes; k++) begin
      wb = wpat(a, k);
      oe_bad = 0;
      for (int j = 7; j >= 0; j--) begin
        bit_cycle(wb[j], g_oe, g_b);
        rb[j] = g_b;
        if (g_oe != (rd && k < cap)) oe_bad++;
      end
      chk(oe_bad == 0, rd ? "R2" : "R7", "oe per data byte", oe_bad, 0);
      if (rd && k < cap)
        chk(rb == rf(13'(int'(a) + k)), "R6", "read byte", int'(rb), int'(rf(13'(int'(a) + k))));
    end
    for (int j = 0; j < extra_bits; j++) bit_cycle(1'b1, g_oe, g_b);
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
    chk(oe == 1'b0, "R7", "oe after select high", int'(oe), 0);
    exp_w = rd ? 0 : cap;
    chk((wn - wn0) == exp_w, rd ? "R1" : "R5", "write count", wn - wn0, exp_w);
    if (!rd) begin
      for (int k = 0; k < cap && (wn0 + k) < 32; k++) begin
        chk(log_a[wn0 + k] == 13'(int'(a) + k), "R4", "write address",
            int'(log_a[wn0 + k]), int'(13'(int'(a) + k)));
        chk(log_d[wn0 + k] == wpat(a, k), "R5", "write data",
            int'(log_d[wn0 + k]), int'(wpat(a, k)));
      end
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic g_oe, g_b;
    int   wn0;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0 && we == 1'b0 && re == 1'b0, "R8", "reset outputs",
        int'({oe, we, re}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: serial clock toggling with select high does nothing
    wn0 = wn;
    for (int i = 0; i < 20; i++) bit_cycle(1'b1, g_oe, g_b);
    chk(wn == wn0 && oe == 1'b0, "R8", "idle with select high", wn - wn0, 0);

    // R1 R2 R3 sweep of direction, length code and host byte count
    for (int rd = 0; rd < 2; rd++)
      for (int len = 0; len < 4; len++)
        for (int nb = 1; nb <= 5; nb++)
          xfer(rd[0], len[1:0], 13'(len * 1111 + nb * 71 + rd * 300), nb, 0);

    // R4 wrap at the top of the address space
    xfer(1'b0, 2'b11, 13'h1FFE, 4, 0);
    xfer(1'b1, 2'b11, 13'h1FFE, 4, 0);
    xfer(1'b0, 2'b10, 13'h1FFF, 3, 0);

    // R5 cut-off byte discarded
    xfer(1'b0, 2'b11, 13'h0123, 2, 5);
    xfer(1'b0, 2'b00, 13'h0456, 0, 7);

    // R9 abandoned command word, then a fresh transaction
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 7; i++) bit_cycle(1'b1, g_oe, g_b);
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
    xfer(1'b0, 2'b01, 13'h0A5A, 2, 0);
    xfer(1'b1, 2'b00, 13'h15A5, 1, 0);

    summary();
    $finish;
  end
endmodule